// File: doc/BRIEF.md
# Synchronous Character Transmitter with Idle Fill

This block turns parallel characters into a continuous serial stream for links that run on a 1X bit clock. The stream carries no framing bits. Each character is 5 to 8 data bits, sent least significant bit first. An optional parity bit follows the data. The host writes characters into a single holding register. The shifter takes a character from that register at each character boundary, and the holding register is ready for the next character again at that point. If the host has nothing ready, the transmitter keeps the line busy with fill characters taken from three programmable registers: two sync patterns and a link-escape character. In transparent mode it also doubles every escape character it sends from host data.

The bit rate comes from `bit_tick`, a one-cycle strobe that stands for the falling edge of the transmit clock. The serial output changes only in the cycle after a strobe. Transmission needs both the enable and the clear-to-send input. When either one drops, the character already in the shifter is finished first, and the line then returns to mark (high). A one-shot command puts a single escape character in front of the next host character.

Top module: `sync_fill_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1 and `tx_empty` is 0.
- R2: After the transmitter is enabled, `txd` stays 1 on every bit strobe until the first character has been written.
- R3: A character is `len_sel`+5 data bits (00=5, 01=6, 10=7, 11=8), sent LSB first. Each bit is held for one strobe interval, and `txd` changes only in the cycle after `bit_tick`.
- R4: With `par_en`=1, one parity bit follows the data bits. With `par_odd`=1 the data bits plus the parity bit hold an odd number of ones. With `par_odd`=0 they hold an even number.
- R5: Consecutive characters follow each other with no gap. The holding register moves to the shifter at the character boundary, and `tx_ready` returns to 1 at that transfer.
- R6: If the holding register is empty at a boundary once transmission has started, fill is sent. Single-sync mode sends `syn1_chr`. Double-sync mode sends the pair `syn1_chr`, `syn2_chr`. Transparent mode sends `dle_chr`, `syn1_chr`. A pair is never split while the transmitter runs, and fill characters carry parity like data.
- R7: `tx_empty` is 0 until fill has started for the first time. It is set when fill starts, stays set while fill repeats, and is cleared by an accepted write.
- R8: In transparent mode, a host character equal to `dle_chr` is followed at once by a second `dle_chr`.
- R9: A pulse on `send_dle` sends one `dle_chr` ahead of the next host character, and the command then clears itself. If that host character is itself `dle_chr`, it is not doubled.
- R10: If `tx_en` or `clr_to_send` is 0 at a boundary, the character in progress has already completed. `txd` then stays 1, and a pending fill pair is dropped. Once transmission is allowed again, the line stays idle until a new character is written.
- R11: A write while `tx_ready` is 0 and no transfer happens in that cycle is ignored: neither the stream nor `tx_ready` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe per bit time (transmit clock falling edge) |
| tx_en | input | 1 | Transmitter enable |
| clr_to_send | input | 1 | Clear-to-send, active high |
| len_sel | input | 2 | Character length select, 5 + value |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| single_syn | input | 1 | 1 = single-sync fill, 0 = sync pair |
| transparent | input | 1 | Transparent mode: escape-sync fill and escape doubling |
| syn1_chr | input | 8 | First sync character |
| syn2_chr | input | 8 | Second sync character |
| dle_chr | input | 8 | Link-escape character |
| send_dle | input | 1 | One-shot send-escape command pulse |
| thr_wr | input | 1 | Holding register write strobe |
| thr_data | input | 8 | Character to write |
| txd | output | 1 | Serial data, high = mark |
| tx_ready | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Fill in progress, no host data |

## Verification
The bench targets the hand-off at character boundaries. If the holding register transfers one strobe late, or the parity bit lands before the last data bit, every following bit of the stream slips. A lost, extra or reordered character shows up in the scoreboard as a run of miscompares.

Each transparent-mode case is checked against the exact escape count. Without doubling, one escape character goes missing. Combining the one-shot command with escape doubling wrongly gives three escapes in a row. A command that never clears puts an escape before every later character.

Stopping is driven in the second half of a fill pair, with both the enable and clear-to-send. A design that cut the character short would show a premature mark. A design that kept running after the boundary would show fill where mark is expected. A design that forgets its idle state would send fill before the next write.

A write into a full holding register is also applied. If it overwrote the register, the corrupted character would appear in the stream.

// File: rtl/sft_pkg.sv
package sft_pkg;
  // Character owed after the one now being shifted
  typedef enum logic [1:0] {
    NXT_NONE = 2'd0,
    NXT_SYN1 = 2'd1,
    NXT_SYN2 = 2'd2,
    NXT_DLE  = 2'd3
  } nxt_e;
endpackage

// File: rtl/sft_holding.sv
module sft_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic              full,
  output logic              accept,
  output logic [DATA_W-1:0] data
);
  // A write lands when the register is free or is being emptied this cycle
  assign accept = wr && (!full || take);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (accept) data <= wdata;
      if (accept)    full <= 1'b1;
      else if (take) full <= 1'b0;
    end
  end
endmodule

// File: rtl/sft_framer.sv
module sft_framer #(
  parameter int DATA_W = 8,
  parameter int LSEL_W = 2,
  parameter int FRM_W  = DATA_W + 1,
  parameter int CNT_W  = $clog2(FRM_W + 1)
) (
  input  logic [DATA_W-1:0] chr,
  input  logic [LSEL_W-1:0] len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  output logic [FRM_W-1:0]  frame,
  output logic [CNT_W-1:0]  nbits
);
  localparam int MIN_LEN = DATA_W - (2 ** LSEL_W) + 1;

  logic [CNT_W-1:0] len;
  logic             par;

  assign len   = CNT_W'(MIN_LEN) + CNT_W'(len_sel);
  assign nbits = len + CNT_W'(par_en);

  always_comb begin
    frame = '0;
    par   = par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(len)) begin
        frame[i] = chr[i];
        par      = par ^ chr[i];
      end
    end
    // parity sits right after the last data bit
    for (int i = 0; i < FRM_W; i++) begin
      if (par_en && i == int'(len)) frame[i] = par;
    end
  end
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter #(
  parameter int FRM_W = 9,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [FRM_W-1:0] frame,
  input  logic [CNT_W-1:0] nbits,
  output logic             txd,
  output logic             at_edge
);
  logic [FRM_W-1:0] sh;
  logic [CNT_W-1:0] left;

  // left counts bits still to go after the one on the line
  assign at_edge = tick && (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      left <= '0;
      txd  <= 1'b1;
    end else if (tick) begin
      if (left != '0) begin
        txd  <= sh[0];
        sh   <= sh >> 1;
        left <= left - CNT_W'(1);
      end else if (load) begin
        txd  <= frame[0];
        sh   <= frame >> 1;
        left <= nbits - CNT_W'(1);
      end else begin
        txd  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_fill_tx.sv
module sync_fill_tx #(
  parameter int DATA_W = 8,
  parameter int LSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              clr_to_send,
  input  logic [LSEL_W-1:0] len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              single_syn,
  input  logic              transparent,
  input  logic [DATA_W-1:0] syn1_chr,
  input  logic [DATA_W-1:0] syn2_chr,
  input  logic [DATA_W-1:0] dle_chr,
  input  logic              send_dle,
  input  logic              thr_wr,
  input  logic [DATA_W-1:0] thr_data,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty
);
  import sft_pkg::*;

  localparam int FRM_W = DATA_W + 1;
  localparam int CNT_W = $clog2(FRM_W + 1);

  logic              hold_full, accept, take;
  logic [DATA_W-1:0] hold_data;
  logic              at_edge, go, run;
  logic [DATA_W-1:0] pick;
  logic [FRM_W-1:0]  frame;
  logic [CNT_W-1:0]  nbits;

  logic started, started_n;
  nxt_e pend, pend_n;
  logic dle_req, dle_use;
  logic no_stuff, no_stuff_n;
  logic fill_go, empty_q;

  sft_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr(thr_wr), .wdata(thr_data), .take(take),
    .full(hold_full), .accept(accept), .data(hold_data)
  );

  sft_framer #(.DATA_W(DATA_W), .LSEL_W(LSEL_W), .FRM_W(FRM_W), .CNT_W(CNT_W)) u_frm (
    .chr(pick), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
    .frame(frame), .nbits(nbits)
  );

  sft_shifter #(.FRM_W(FRM_W), .CNT_W(CNT_W)) u_shf (
    .clk(clk), .rst(rst), .tick(bit_tick), .load(go), .frame(frame),
    .nbits(nbits), .txd(txd), .at_edge(at_edge)
  );

  assign run = tx_en && clr_to_send;

  // Next-character selection at a character boundary
  always_comb begin
    go         = 1'b0;
    take       = 1'b0;
    dle_use    = 1'b0;
    fill_go    = 1'b0;
    pick       = hold_data;
    pend_n     = pend;
    started_n  = started;
    no_stuff_n = no_stuff;
    if (at_edge) begin
      if (!run) begin
        pend_n     = NXT_NONE;
        started_n  = 1'b0;
        no_stuff_n = 1'b0;
      end else if (pend != NXT_NONE) begin
        go     = 1'b1;
        pend_n = NXT_NONE;
        case (pend)
          NXT_SYN1: pick = syn1_chr;
          NXT_SYN2: pick = syn2_chr;
          default:  pick = dle_chr;
        endcase
      end else if (hold_full) begin
        go        = 1'b1;
        started_n = 1'b1;
        if (dle_req) begin
          pick       = dle_chr;
          dle_use    = 1'b1;
          no_stuff_n = 1'b1;
        end else begin
          take       = 1'b1;
          no_stuff_n = 1'b0;
          if (transparent && hold_data == dle_chr && !no_stuff) pend_n = NXT_DLE;
        end
      end else if (started) begin
        go      = 1'b1;
        fill_go = 1'b1;
        if (transparent) begin
          pick   = dle_chr;
          pend_n = NXT_SYN1;
        end else begin
          pick = syn1_chr;
          if (!single_syn) pend_n = NXT_SYN2;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started  <= 1'b0;
      pend     <= NXT_NONE;
      dle_req  <= 1'b0;
      no_stuff <= 1'b0;
      empty_q  <= 1'b0;
    end else begin
      started  <= started_n;
      pend     <= pend_n;
      no_stuff <= no_stuff_n;
      if (send_dle)     dle_req <= 1'b1;
      else if (dle_use) dle_req <= 1'b0;
      if (accept)       empty_q <= 1'b0;
      else if (fill_go) empty_q <= 1'b1;
    end
  end

  assign tx_ready = ~hold_full;
  assign tx_empty = empty_q;
endmodule

// File: rtl/sft_chk.sv
module sft_chk (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic tx_en,
  input logic clr_to_send,
  input logic thr_wr,
  input logic txd,
  input logic tx_ready,
  input logic tx_empty,
  input logic at_edge,
  input logic take,
  input logic started
);
  AST_TXD_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(txd)); // R3

  AST_READY_ON_TRANSFER: assert property (@(posedge clk) disable iff (rst)
    (take && !thr_wr) |=> tx_ready); // R5

  AST_EMPTY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> $past(started)); // R7

  AST_EMPTY_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (thr_wr && tx_ready) |=> !tx_empty); // R7

  AST_MARK_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (at_edge && !(tx_en && clr_to_send)) |=> txd); // R10

  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (thr_wr && !tx_ready && !take) |=> !tx_ready); // R11
endmodule

bind sync_fill_tx sft_chk u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_en(tx_en),
  .clr_to_send(clr_to_send), .thr_wr(thr_wr), .txd(txd), .tx_ready(tx_ready),
  .tx_empty(tx_empty), .at_edge(at_edge), .take(take), .started(started)
);

// File: tb/sync_fill_tx_tb.sv
module sync_fill_tx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic       tx_en = 1'b0, clr_to_send = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, single_syn = 1'b1, transparent = 1'b0;
  logic [7:0] syn1_chr = 8'h16, syn2_chr = 8'h2D, dle_chr = 8'h10;
  logic       send_dle = 1'b0, thr_wr = 1'b0;
  logic [7:0] thr_data = 8'h00;
  logic       txd, tx_ready, tx_empty;

  int    n_vec = 0, n_bad = 0;
  int    tcnt = 0;
  bit    exp_q[$];
  bit    e_bit;
  logic [7:0] chr_q[$];
  string cur_req = "R1";
  event  bit_ev;

  always #2.5 clk = ~clk;

  sync_fill_tx u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_en(tx_en), .clr_to_send(clr_to_send),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .single_syn(single_syn),
    .transparent(transparent), .syn1_chr(syn1_chr), .syn2_chr(syn2_chr), .dle_chr(dle_chr),
    .send_dle(send_dle), .thr_wr(thr_wr), .thr_data(thr_data),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  // Monitor: compares each bit after a strobe, then generates the next strobe
  always @(negedge clk) begin
    if (!rst && bit_tick) begin
      if (exp_q.size() > 0) begin
        e_bit = exp_q.pop_front();
        n_vec++;
        if (txd !== e_bit) begin
          n_bad++;
          $display("FAIL %s: txd=%b expected %b", cur_req, txd, e_bit);
        end
      end
      -> bit_ev;
    end
    tcnt = (tcnt + 1) % 4;
    bit_tick = (tcnt == 3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  // Reference character: data LSB first then parity (R3, R4)
  task automatic push_chr(input logic [7:0] c);
    bit p;
    p = par_odd;
    for (int i = 0; i < 5 + int'(len_sel); i++) begin
      exp_q.push_back(c[i]);
      p = p ^ c[i];
    end
    if (par_en) exp_q.push_back(p);
  endtask

  task automatic run_scn(input string tag, input int pre, input bit stop_cts,
                         input bit junk, input bit cmd, input bit first);
    int  k, idx, nb;
    bit  cmd_pend, junk_done, junk_chk, emp_chk;
    cur_req = tag;
    exp_q.delete();
    @(bit_ev);
    tx_en = 1'b1;
    clr_to_send = 1'b1;
    if (cmd) send_dle = 1'b1;
    for (int i = 0; i < pre; i++) exp_q.push_back(1'b1);   // R2 idle mark
    cmd_pend = cmd;
    foreach (chr_q[i]) begin
      if (cmd_pend) begin                                    // R9
        push_chr(dle_chr);
        cmd_pend = 1'b0;
        push_chr(chr_q[i]);
      end else begin
        push_chr(chr_q[i]);
        if (transparent && chr_q[i] == dle_chr) push_chr(dle_chr); // R8
      end
    end
    if (transparent) begin push_chr(dle_chr); push_chr(syn1_chr); end  // R6
    else if (single_syn) push_chr(syn1_chr);
    else begin push_chr(syn1_chr); push_chr(syn2_chr); end
    nb = exp_q.size();
    exp_q.push_back(1'b1);                                   // R10 mark after stop
    exp_q.push_back(1'b1);
    if (first) chk(tx_empty == 1'b0, "R7 before first char", tx_empty, 0);
    k = 0; idx = 0; junk_done = 0; junk_chk = 0; emp_chk = 0;
    while (exp_q.size() > 0) begin
      if (idx == 1 && !emp_chk) begin
        chk(tx_empty == 1'b0, "R7 cleared by write", tx_empty, 0);
        emp_chk = 1'b1;
      end
      if (idx < chr_q.size() && k >= pre && tx_ready) begin
        thr_data = chr_q[idx];
        thr_wr = 1'b1;
        idx++;
      end else if (junk && idx >= 2 && !junk_done && !tx_ready) begin
        thr_data = 8'hFF;                                    // R11
        thr_wr = 1'b1;
        junk_done = 1'b1;
      end
      if (k == nb - 1) begin
        if (stop_cts) clr_to_send = 1'b0;
        else tx_en = 1'b0;
      end
      @(negedge clk);
      thr_wr = 1'b0;
      send_dle = 1'b0;
      if (junk_done && !junk_chk) begin
        chk(tx_ready == 1'b0, "R11 ready unchanged", tx_ready, 0);
        junk_chk = 1'b1;
      end
      @(bit_ev);
      k++;
    end
    chk(tx_empty == 1'b1, "R7 set by fill", tx_empty, 1);
    chk(tx_ready == 1'b1, "R5 ready after transfer", tx_ready, 1);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
        chk(tx_empty == 1'b0, "R1 tx_empty", tx_empty, 0);

        // 8-bit, no parity, single sync fill, stop by enable
        len_sel = 2'd3; par_en = 0; single_syn = 1; transparent = 0;
        chr_q = '{8'hA5, 8'h3C};
        run_scn("R2 R3 R5 R6 R10", 3, 1'b0, 1'b0, 1'b0, 1'b1);

        // 7-bit even parity, sync pair fill, full write, stop by clear-to-send
        len_sel = 2'd2; par_en = 1; par_odd = 0; single_syn = 0;
        chr_q = '{8'h55, 8'h0F, 8'h7E};
        run_scn("R4 R6 R10 R11", 3, 1'b1, 1'b1, 1'b0, 1'b0);

        // 5-bit odd parity, transparent, escape doubling
        len_sel = 2'd0; par_en = 1; par_odd = 1; transparent = 1;
        chr_q = '{8'h10, 8'h0B, 8'h10};
        run_scn("R4 R8", 0, 1'b0, 1'b0, 1'b0, 1'b0);

        // 6-bit transparent, one-shot escape before an escape
        len_sel = 2'd1; par_en = 0;
        chr_q = '{8'h10, 8'h12};
        run_scn("R9 R8", 0, 1'b1, 1'b0, 1'b1, 1'b0);

        // 8-bit sync pair, one-shot escape before ordinary data
        len_sel = 2'd3; transparent = 0; single_syn = 0;
        chr_q = '{8'h5A, 8'hC3};
        run_scn("R9 R6", 2, 1'b0, 1'b0, 1'b1, 1'b0);
      end
      begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule